// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading an in-memory translation table of two levels. A caller presents the virtual address together with the current table base. The walker reads one word from the first-level table, which is 16 KB, sits on a 16 KB boundary and has one entry for each 1 MB of virtual space. That entry either maps the whole megabyte directly as a section or points to a second-level table. Two kinds of second-level table are supported. A coarse table is 1 KB and is indexed by eight virtual-address bits. A fine table is 4 KB and is indexed by ten bits. The second word read from such a table describes a large page (64 KB), a small page (4 KB) or a tiny page (1 KB).

The walker returns the physical address, the 4-bit domain from the first-level entry, the raw 2-bit access-permission field and the page kind. An invalid descriptor at either level produces a translation fault, together with the level at which it was found. Memory is reached through a plain word-read port: a request carries a byte address, and the response returns one 32-bit word in the same cycle or in any later cycle. The block does not cache translations, interpret cache attributes or check permissions.

The sequencer has four states:
- `ST_IDLE` waits for a request.
- `ST_L1_FETCH` reads the first-level entry.
- `ST_L2_FETCH` reads the second-level entry.
- `ST_DONE` presents the result for one cycle.

The transitions are:
- IDLE→L1_FETCH when a request is accepted.
- L1_FETCH→DONE on a fault or a section.
- L1_FETCH→L2_FETCH on a coarse or fine table pointer.
- L2_FETCH→DONE on any second-level response.
- DONE→IDLE unconditionally.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: A request is accepted only in the idle state. `req_ready` stays 0 from acceptance until the cycle after `done`. `req_va` and `ttb` are sampled only at acceptance, so changes to them during a walk have no effect on the result.
- R3: In the cycle after acceptance, the walker requests address {ttb[31:14], va[31:20], 2'b00}.
- R4: Each fetch raises `mem_req_valid` for exactly one cycle. A response in that same cycle or in any later cycle completes the fetch.
- R5: A first-level descriptor with bits [1:0] = 00 ends the walk with fault=1 and fault_level=1. In that case pa, ap, page_kind and domain are all 0.
- R6: A first-level descriptor with bits [1:0] = 10 is a section. There is no second fetch. The results are pa = {d1[31:20], va[19:0]}, ap = d1[11:10], page_kind = 0 and domain = d1[8:5].
- R7: First-level code 01 points to a coarse table, and the second fetch address is {d1[31:10], va[19:12], 2'b00}. Code 11 points to a fine table, and the address is {d1[31:12], va[19:10], 2'b00}.
- R8: A second-level descriptor with bits [1:0] = 00 gives fault=1 and fault_level=2. The domain is still taken from d1[8:5]. pa, ap and page_kind are 0.
- R9: Second-level code 01 is a large page. The results are pa = {d2[31:16], va[15:0]} and page_kind = 1. ap = d2[4+2k +: 2], where k = va[15:14].
- R10: Second-level code 10 is a small page. The results are pa = {d2[31:12], va[11:0]} and page_kind = 2. ap = d2[4+2k +: 2], where k = va[11:10].
- R11: Second-level code 11 is a tiny page. The results are pa = {d2[31:10], va[9:0]}, ap = d2[5:4] and page_kind = 3.
- R12: `done` is a single-cycle pulse. `fault_level` is 0 whenever `fault` is 0, and the domain of a successful walk is d1[8:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 32 | Virtual address to translate |
| ttb | input | 32 | Translation table base (bits [31:14] used) |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Translation fault |
| fault_level | output | 2 | 0 none, 1 first level, 2 second level |
| pa | output | 32 | Physical address |
| domain | output | 4 | Domain from first-level entry |
| ap | output | 2 | Selected access-permission bits |
| page_kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |

## Verification
The bench runs every pairing of first-level and second-level descriptor codes. The virtual addresses are varied so that each value of the two subpage selector fields is used. The difference between a coarse and a fine index shows up in the second fetch address. Subpage selection is separated by ap: va[15:14] is checked against va[11:10] for large and small pages, and tiny pages ignore both fields. Response latencies of 0, 1 and 2 cycles show whether a same-cycle response and a delayed response are both handled. During each walk the request inputs are changed to inverted values, which shows whether they are sampled only at acceptance.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_L1_FETCH = 2'd1,
        ST_L2_FETCH = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_SECTION = 2'd0,
        KIND_LARGE   = 2'd1,
        KIND_SMALL   = 2'd2,
        KIND_TINY    = 2'd3
    } page_kind_e;

    // descriptor type codes (bits [1:0])
    localparam logic [1:0] D1_INVALID = 2'b00;
    localparam logic [1:0] D1_COARSE  = 2'b01;
    localparam logic [1:0] D1_SECTION = 2'b10;
    localparam logic [1:0] D1_FINE    = 2'b11;
    localparam logic [1:0] D2_INVALID = 2'b00;
    localparam logic [1:0] D2_LARGE   = 2'b01;
    localparam logic [1:0] D2_SMALL   = 2'b10;
    localparam logic [1:0] D2_TINY    = 2'b11;

    // address-split points
    localparam int TTB_LSB     = 14;
    localparam int SECTION_LSB = 20;
    localparam int LARGE_LSB   = 16;
    localparam int SMALL_LSB   = 12;
    localparam int TINY_LSB    = 10;
    localparam int COARSE_LSB  = 10;
    localparam int FINE_LSB    = 12;
    localparam int DOM_LSB     = 5;
    localparam int DOM_W       = 4;
    localparam int AP_W        = 2;
    localparam int SEC_AP_LSB  = 10;
    localparam int SUB_AP_LSB  = 4;

    typedef struct packed {
        logic             fault;
        logic [1:0]       level;
        logic [31:0]      pa;
        logic [DOM_W-1:0] domain;
        logic [AP_W-1:0]  ap;
        page_kind_e       kind;
    } walk_result_t;

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output walk_result_t      res,
    output logic              go_l2,
    output logic [ADDR_W-1:0] l2_addr
);
    localparam int COARSE_IDX_W = SECTION_LSB - SMALL_LSB;
    localparam int FINE_IDX_W   = SECTION_LSB - TINY_LSB;

    logic unused_va_bits;
    assign unused_va_bits = ^{va[ADDR_W-1:SECTION_LSB], desc[9], desc[4:2]};

    always_comb begin
        res     = '0;
        go_l2   = 1'b0;
        l2_addr = '0;
        unique case (desc[1:0])
            D1_INVALID: begin
                res.fault = 1'b1;
                res.level = 2'd1;
            end
            D1_SECTION: begin
                res.pa     = {desc[ADDR_W-1:SECTION_LSB], va[SECTION_LSB-1:0]};
                res.ap     = desc[SEC_AP_LSB +: AP_W];
                res.domain = desc[DOM_LSB +: DOM_W];
                res.kind   = KIND_SECTION;
            end
            D1_COARSE: begin
                go_l2   = 1'b1;
                l2_addr = {desc[ADDR_W-1:COARSE_LSB],
                           va[SMALL_LSB +: COARSE_IDX_W], 2'b00};
            end
            D1_FINE: begin
                go_l2   = 1'b1;
                l2_addr = {desc[ADDR_W-1:FINE_LSB],
                           va[TINY_LSB +: FINE_IDX_W], 2'b00};
            end
        endcase
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] l1_desc,
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output walk_result_t      res
);
    logic [1:0]        sub_sel;
    logic [4:0]        ap_shift;
    logic [ADDR_W-1:0] shifted;
    logic              unused_l1_bits;

    assign unused_l1_bits = ^{l1_desc[ADDR_W-1:DOM_LSB+DOM_W], l1_desc[DOM_LSB-1:0],
                              va[ADDR_W-1:LARGE_LSB], va[13:12]};

    always_comb begin
        sub_sel  = (desc[1:0] == D2_LARGE) ? va[15:14] : va[11:10];
        ap_shift = 5'(SUB_AP_LSB) + {2'b00, sub_sel, 1'b0};
        shifted  = desc >> ap_shift;
        res        = '0;
        res.domain = l1_desc[DOM_LSB +: DOM_W];
        unique case (desc[1:0])
            D2_INVALID: begin
                res.fault = 1'b1;
                res.level = 2'd2;
            end
            D2_LARGE: begin
                res.pa   = {desc[ADDR_W-1:LARGE_LSB], va[LARGE_LSB-1:0]};
                res.ap   = shifted[AP_W-1:0];
                res.kind = KIND_LARGE;
            end
            D2_SMALL: begin
                res.pa   = {desc[ADDR_W-1:SMALL_LSB], va[SMALL_LSB-1:0]};
                res.ap   = shifted[AP_W-1:0];
                res.kind = KIND_SMALL;
            end
            D2_TINY: begin
                res.pa   = {desc[ADDR_W-1:TINY_LSB], va[TINY_LSB-1:0]};
                res.ap   = desc[SUB_AP_LSB +: AP_W];
                res.kind = KIND_TINY;
            end
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    input  logic [ADDR_W-1:0] ttb,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_level,
    output logic [ADDR_W-1:0] pa,
    output logic [3:0]        domain,
    output logic [1:0]        ap,
    output logic [1:0]        page_kind
);
    localparam int L1_IDX_W = ADDR_W - SECTION_LSB;

    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] va_q, ttb_q, l1_q;
    logic              issued_q;
    walk_result_t      res_q, l1_res, l2_res;
    logic              go_l2;
    logic [ADDR_W-1:0] l1_addr, l2_addr, l2_addr_q;
    logic              in_fetch, rsp_take;
    logic              unused_ttb_bits;

    assign unused_ttb_bits = ^ttb_q[TTB_LSB-1:0];

    assign l1_addr  = {ttb_q[ADDR_W-1:TTB_LSB], va_q[SECTION_LSB +: L1_IDX_W], 2'b00};
    assign in_fetch = (state_q == ST_L1_FETCH) || (state_q == ST_L2_FETCH);
    assign rsp_take = in_fetch && mem_rsp_valid;

    ptw_l1_decode #(.ADDR_W(ADDR_W)) l1_dec_i (
        .desc(mem_rsp_data), .va(va_q), .res(l1_res), .go_l2(go_l2), .l2_addr(l2_addr)
    );

    ptw_l2_decode #(.ADDR_W(ADDR_W)) l2_dec_i (
        .l1_desc(l1_q), .desc(mem_rsp_data), .va(va_q), .res(l2_res)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_L1_FETCH;
            ST_L1_FETCH: if (mem_rsp_valid) state_d = go_l2 ? ST_L2_FETCH : ST_DONE;
            ST_L2_FETCH: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            ttb_q     <= '0;
            l1_q      <= '0;
            l2_addr_q <= '0;
            issued_q  <= 1'b0;
            res_q     <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q  <= req_va;
                ttb_q <= ttb;
            end
            if (rsp_take)            issued_q <= 1'b0;
            else if (mem_req_valid)  issued_q <= 1'b1;
            if (state_q == ST_L1_FETCH && mem_rsp_valid) begin
                l1_q      <= mem_rsp_data;
                l2_addr_q <= l2_addr;
                if (!go_l2) res_q <= l1_res;
            end
            if (state_q == ST_L2_FETCH && mem_rsp_valid) res_q <= l2_res;
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = in_fetch && !issued_q;
        mem_req_addr  = (state_q == ST_L2_FETCH) ? l2_addr_q : l1_addr;
        done          = (state_q == ST_DONE);
        fault         = res_q.fault;
        fault_level   = res_q.level;
        pa            = res_q.pa;
        domain        = res_q.domain;
        ap            = res_q.ap;
        page_kind     = res_q.kind;
    end

    // R3
    l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid &&
            mem_req_addr == {$past(ttb[ADDR_W-1:TTB_LSB]), $past(req_va[ADDR_W-1:SECTION_LSB]), 2'b00}));

    // R4
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> !mem_req_valid);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fault ? (fault_level != 2'd0) : (fault_level == 2'd0)));

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || mem_req_valid) |-> !req_ready);

    // R6
    section_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && page_kind == KIND_SECTION) |->
            pa[SECTION_LSB-1:0] == va_q[SECTION_LSB-1:0]);
endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] ttb = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [1:0]  fault_level, ap, page_kind;
    logic [31:0] pa;
    logic [3:0]  domain;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .ttb(ttb), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .fault_level(fault_level), .pa(pa), .domain(domain), .ap(ap),
        .page_kind(page_kind)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] tb_base,
                            input logic [31:0] d1, input logic [31:0] d2, input int lat);
        logic [31:0] e_a1, e_a2, e_pa;
        logic [3:0]  e_dom;
        logic [1:0]  e_ap, e_kind, e_lvl;
        logic        e_fault;
        int          e_fetches, nfetch, tmo, k;
        string       tag;
        bit          got_done;
        e_a1 = {tb_base[31:14], va[31:20], 2'b00};
        e_a2 = '0; e_pa = '0; e_dom = '0; e_ap = '0; e_kind = '0; e_lvl = '0;
        e_fault = 1'b0; e_fetches = 1;
        case (d1[1:0])
            2'b00: begin e_fault = 1; e_lvl = 1; tag = "R5"; end
            2'b10: begin
                e_pa = {d1[31:20], va[19:0]}; e_ap = d1[11:10];
                e_dom = d1[8:5]; e_kind = 0; tag = "R6";
            end
            default: begin
                e_fetches = 2;
                e_dom = d1[8:5];
                e_a2 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00}
                                          : {d1[31:12], va[19:10], 2'b00};
                case (d2[1:0])
                    2'b00: begin e_fault = 1; e_lvl = 2; tag = "R8"; end
                    2'b01: begin
                        k = int'(va[15:14]);
                        e_pa = {d2[31:16], va[15:0]}; e_ap = 2'((d2 >> (4 + 2*k)) & 3);
                        e_kind = 1; tag = "R9";
                    end
                    2'b10: begin
                        k = int'(va[11:10]);
                        e_pa = {d2[31:12], va[11:0]}; e_ap = 2'((d2 >> (4 + 2*k)) & 3);
                        e_kind = 2; tag = "R10";
                    end
                    default: begin
                        e_pa = {d2[31:10], va[9:0]}; e_ap = d2[5:4];
                        e_kind = 3; tag = "R11";
                    end
                endcase
            end
        endcase
        if (e_fault) e_pa = '0;
        if (e_fault && e_lvl == 1) e_dom = '0;

        @(negedge clk);
        req_valid = 1; req_va = va; ttb = tb_base;
        @(negedge clk);
        req_va = ~va; ttb = ~tb_base;   // R2: must not disturb walk
        nfetch = 0; tmo = 0; got_done = 0;
        while (!got_done && tmo < 60) begin
            if (done) got_done = 1;
            else if (mem_req_valid) begin
                chk("R2", "ready while busy", {31'b0, req_ready}, 32'd0);
                if (nfetch == 0) chk("R3", "l1 addr", mem_req_addr, e_a1);
                else             chk("R7", "l2 addr", mem_req_addr, e_a2);
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    chk("R4", "request repeated", {31'b0, mem_req_valid}, 32'd0);
                end
                mem_rsp_valid = 1;
                mem_rsp_data = (nfetch == 0) ? d1 : d2;
                nfetch++;
                @(negedge clk);
                mem_rsp_valid = 0;
                mem_rsp_data = 32'hDEAD_BEEF;
            end else begin
                @(negedge clk);
                tmo++;
            end
        end
        req_valid = 0;
        chk("R4", "walk finished", {31'b0, got_done}, 32'd1);
        chk(tag, "fetch count", nfetch, e_fetches);
        chk(tag, "fault", {31'b0, fault}, {31'b0, e_fault});
        chk("R12", "fault_level", {30'b0, fault_level}, {30'b0, e_lvl});
        chk(tag, "pa", pa, e_pa);
        chk(tag, "domain", {28'b0, domain}, {28'b0, e_dom});
        chk(tag, "ap", {30'b0, ap}, {30'b0, e_ap});
        chk(tag, "page_kind", {30'b0, page_kind}, {30'b0, e_kind});
        @(negedge clk);
        chk("R12", "done pulse", {31'b0, done}, 32'd0);
        chk("R2", "ready after walk", {31'b0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1", "done", {31'b0, done}, 32'd0);
        chk("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        for (int b = 0; b < 2; b++) begin
            for (int t1 = 0; t1 < 4; t1++) begin
                for (int t2 = 0; t2 < 4; t2++) begin
                    for (int s = 0; s < 4; s++) begin
                        logic [31:0] h, va, d1, d2, tbv;
                        h   = 32'h9E37_79B9 * (b*64 + t1*16 + t2*4 + s + 1);
                        va  = h ^ 32'h5A5A_1234;
                        va[15:14] = 2'(s);
                        va[11:10] = 2'(3 - s);
                        d1  = {h[15:0], h[31:16]};
                        d1[1:0] = 2'(t1);
                        d2  = h * 32'd2654435761;
                        d2[1:0] = 2'(t2);
                        tbv = (b == 0) ? 32'hA5A5_C000 : 32'h1234_7FFF;
                        run_walk(va, tbv, d1, d2, (t1 + t2 + s + b) % 3);
                    end
                end
            end
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule